// File: doc/BRIEF.md
# Dual-Copy Timekeeper Register Window

This block is a sixteen-byte register window placed over a chain of BCD time-of-day counters. Every time field exists twice: an internal counter that advances once per second from a single-cycle `sec_tick` pulse, and a user copy that software reads and writes over a small synchronous bus. After each tick that advances the counters, the user copy is refreshed from them in a single clock. All fields are updated together, so a read never sees a half-carried time.

A control byte holds two freeze bits. The READ bit stops refreshes of the user copy while the counters keep running, so software gets a stable snapshot. The WRITE bit also stops refreshes, and it also stops counting. Software then loads new values into the user copy. Clearing the WRITE bit copies those values into the counters in one step. A STOP bit in the seconds byte halts the oscillator. A frequency-test bit in the day byte is stored. Software may change either bit at any time without using the WRITE bit. The bytes that carry no time field are plain read/write storage.

Top module: `tk_regwin`

## Requirements
- R1: Offsets 0 and 2 to 7 are plain byte storage that reads back what was written and is untouched by refreshes. Read data is registered: it shows the byte at the address presented on the previous clock edge.
- R2: After reset, the control byte (offset 8) and every user byte read 00. The counters start at 00:00:00, day 1, date 01, month 01, year 00, century 00, so the first refresh shows seconds 01, day 01, date 01, month 01.
- R3: Each tick advances the counters by one second, provided STOP and WRITE are both 0. One clock after a tick that arrives while READ and WRITE are both 0, every user time byte is refreshed together from the counters.
- R4: Seconds (offset 9) and minutes (offset A) roll from 59 to 00. Hours (offset B) roll from 23 to 00. Day of week (offset C) runs 1 to 7 and returns to 1 when the hour rolls over.
- R5: Date (offset D) wraps to 01 after the last day of its month (offset E). Months 04, 06, 09 and 11 have 30 days. February has 29 days when the BCD year (offset F) is divisible by 4, with 00 included, and 28 days otherwise. The other months have 31 days. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century byte at offset 1.
- R6: While the READ bit (offset 8, bit 6) is 1, the user copy keeps its values and the counters keep running. After READ returns to 0, the user copy stays unchanged until the next tick, which refreshes it with the current count.
- R7: Setting READ in the clock right after a tick does not cancel the refresh that tick started: the user copy still shows the new time.
- R8: While the WRITE bit (offset 8, bit 7) is 1, ticks do not refresh the user copy, and the user copy accepts new time bytes. A write that changes WRITE from 1 to 0 loads offsets 9 to F and offset 1 into the counters. The next tick then shows the loaded time plus one second.
- R9: A write to offset 9 sets the STOP bit from bit 7 and takes effect whatever the state of the freeze bits. While STOP is 1, ticks do not advance the counters, and offset 9 reads with bit 7 set. The frequency-test bit (offset C, bit 6) is written and read back the same way.
- R10: On commit, the counters keep only the field bits: seconds and minutes bits 6:0, hours and date bits 5:0, day bits 2:0, month bits 4:0, and year and century in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W (4) | Register offset for read and write |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previous cycle's address |

## Verification
The carry and rollover properties assume that the counters hold valid BCD. That holds after reset and whenever software commits valid BCD times, so the bench loads only well-formed time values and keeps the STOP bit clear when it loads seconds. The property on the completed refresh assumes that the bus does not write during the refresh clock, except for the control write in the READ-race test. Ticks are always at least two clocks apart, so a refresh and the next count never overlap in a way the bench has to reason about.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] mins;
    logic [7:0] secs;
  } tk_time_t;

  localparam int OFF_CENT  = 1;
  localparam int OFF_CTRL  = 8;
  localparam int OFF_SEC   = 9;
  localparam int OFF_MIN   = 10;
  localparam int OFF_HOUR  = 11;
  localparam int OFF_DOW   = 12;
  localparam int OFF_DATE  = 13;
  localparam int OFF_MONTH = 14;
  localparam int OFF_YEAR  = 15;

  localparam int CTRL_WR_BIT = 7;
  localparam int CTRL_RD_BIT = 6;
  localparam int STOP_BIT    = 7;
  localparam int FTEST_BIT   = 6;

  localparam tk_time_t TIME_AT_RESET = '{cent: 8'h00, year: 8'h00, month: 8'h01,
                                         date: 8'h01, dow: 8'h01, hour: 8'h00,
                                         mins: 8'h00, secs: 8'h00};

  // Next BCD value, wrapping from 'last' to 'first'.
  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] last,
                                          input logic [7:0] first);
    if (v == last)            return first;
    else if (v[3:0] == 4'd9)  return {v[7:4] + 4'd1, 4'd0};
    else                      return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Every fourth BCD year: odd tens with units 2 or 6, even tens with 0, 4 or 8.
  function automatic logic bcd_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tk_counter_chain.sv
module tk_counter_chain
  import tk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  input  logic     load,
  input  tk_time_t load_val,
  output tk_time_t now
);

  tk_time_t   nxt;
  logic [7:0] last_date;
  logic       c_sec, c_min, c_hour, c_date, c_month, c_year;

  always_comb begin
    last_date = month_last(now.month, now.year);
    c_sec     = (now.secs == 8'h59);
    c_min     = c_sec  && (now.mins == 8'h59);
    c_hour    = c_min  && (now.hour == 8'h23);
    c_date    = c_hour && (now.date == last_date);
    c_month   = c_date && (now.month == 8'h12);
    c_year    = c_month && (now.year == 8'h99);

    nxt      = now;
    nxt.secs = bcd_step(now.secs, 8'h59, 8'h00);
    if (c_sec)   nxt.mins  = bcd_step(now.mins, 8'h59, 8'h00);
    if (c_min)   nxt.hour  = bcd_step(now.hour, 8'h23, 8'h00);
    if (c_hour) begin
      nxt.dow  = bcd_step(now.dow, 8'h07, 8'h01);
      nxt.date = bcd_step(now.date, last_date, 8'h01);
    end
    if (c_date)  nxt.month = bcd_step(now.month, 8'h12, 8'h01);
    if (c_month) nxt.year  = bcd_step(now.year, 8'h99, 8'h00);
    if (c_year)  nxt.cent  = bcd_step(now.cent, 8'h99, 8'h00);
  end

  always_ff @(posedge clk) begin
    if (rst)       now <= TIME_AT_RESET;
    else if (load) now <= load_val;
    else if (step) now <= nxt;
  end

  // R4: seconds wrap
  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !load && now.secs == 8'h59) |=> (now.secs == 8'h00));

  // R4: day of week wraps from 7 to 1 at midnight
  assert_dow_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !load && now.secs == 8'h59 && now.mins == 8'h59 && now.hour == 8'h23
     && now.dow == 8'h07) |=> (now.dow == 8'h01 && now.hour == 8'h00));

  // R5: year end wraps date and month
  assert_year_end_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && now.secs == 8'h59 && now.mins == 8'h59 && now.hour == 8'h23
     && now.date == 8'h31 && now.month == 8'h12) |=> (now.month == 8'h01 && now.date == 8'h01));

  // R9: no step and no load keeps the count
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(now));

  // R8: commit copies the load value
  assert_commit_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (now == $past(load_val)));

endmodule

// File: rtl/tk_user_window.sv
module tk_user_window
  import tk_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  tk_time_t          now,
  output logic [7:0]        rdata,
  output logic              hold,
  output logic              load,
  output tk_time_t          load_val
);

  localparam int NUM_REGS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] A_CENT  = ADDR_W'(OFF_CENT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(OFF_SEC);
  localparam logic [ADDR_W-1:0] A_MIN   = ADDR_W'(OFF_MIN);
  localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(OFF_HOUR);
  localparam logic [ADDR_W-1:0] A_DOW   = ADDR_W'(OFF_DOW);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(OFF_DATE);
  localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(OFF_MONTH);
  localparam logic [ADDR_W-1:0] A_YEAR  = ADDR_W'(OFF_YEAR);

  logic [7:0] ucopy [NUM_REGS];
  logic       stop_q, ftest_q, pend;
  logic       rd_freeze, wr_freeze;
  logic [7:0] rd_byte, ucopy_secs;

  assign rd_freeze  = ucopy[A_CTRL][CTRL_RD_BIT];
  assign wr_freeze  = ucopy[A_CTRL][CTRL_WR_BIT];
  assign ucopy_secs = ucopy[A_SEC];
  assign hold       = stop_q || wr_freeze;
  assign load       = wr_en && (addr == A_CTRL) && wr_freeze && !wdata[CTRL_WR_BIT];

  always_comb begin
    load_val       = '0;
    load_val.secs  = {1'b0, ucopy[A_SEC][6:0]};
    load_val.mins  = {1'b0, ucopy[A_MIN][6:0]};
    load_val.hour  = {2'b0, ucopy[A_HOUR][5:0]};
    load_val.dow   = {5'b0, ucopy[A_DOW][2:0]};
    load_val.date  = {2'b0, ucopy[A_DATE][5:0]};
    load_val.month = {3'b0, ucopy[A_MONTH][4:0]};
    load_val.year  = ucopy[A_YEAR];
    load_val.cent  = ucopy[A_CENT];
  end

  // A tick seen while unfrozen schedules one bulk refresh on the next clock.
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= tick && !rd_freeze && !wr_freeze;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) ucopy[i] <= 8'h00;
    end else begin
      if (pend) begin
        ucopy[A_SEC]   <= {1'b0, now.secs[6:0]};
        ucopy[A_MIN]   <= now.mins;
        ucopy[A_HOUR]  <= now.hour;
        ucopy[A_DOW]   <= now.dow;
        ucopy[A_DATE]  <= now.date;
        ucopy[A_MONTH] <= now.month;
        ucopy[A_YEAR]  <= now.year;
        ucopy[A_CENT]  <= now.cent;
      end
      if (wr_en) ucopy[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q  <= 1'b0;
      ftest_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_SEC) stop_q  <= wdata[STOP_BIT];
      if (addr == A_DOW) ftest_q <= wdata[FTEST_BIT];
    end
  end

  always_comb begin
    rd_byte = ucopy[addr];
    if (addr == A_SEC) rd_byte[STOP_BIT]  = stop_q;
    if (addr == A_DOW) rd_byte[FTEST_BIT] = ftest_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_byte;
  end

  // R6: a frozen copy holds while no refresh or write is under way
  assert_read_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_freeze && !pend && !wr_en) |=> $stable(ucopy_secs));

  // R7: a started refresh completes
  assert_refresh_done_R7: assert property (@(posedge clk) disable iff (rst)
    (pend && !wr_en) |=> (ucopy_secs == {1'b0, $past(now.secs[6:0])}));

  // R3: no refresh without a tick in the previous cycle
  assert_no_stray_refresh_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> !pend);

endmodule

// File: rtl/tk_regwin.sv
module tk_regwin
  import tk_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  tk_time_t now, load_val;
  logic     hold, load, step;

  assign step = sec_tick && !hold;

  tk_user_window #(.ADDR_W(ADDR_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .tick     (sec_tick),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .now      (now),
    .rdata    (rdata),
    .hold     (hold),
    .load     (load),
    .load_val (load_val)
  );

  tk_counter_chain u_chain (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .load     (load),
    .load_val (load_val),
    .now      (now)
  );

endmodule

// File: tb/tb_tk_regwin.sv
module tb_tk_regwin;

  logic       clk = 1'b0;
  logic       rst, sec_tick, wr_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  int         checks = 0, fails = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  tk_regwin dut (.clk(clk), .rst(rst), .sec_tick(sec_tick), .addr(addr),
                 .wr_en(wr_en), .wdata(wdata), .rdata(rdata));

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input string what, input logic [3:0] a,
                        input logic [7:0] exp);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    chk(req, what, rdata, exp);
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] ce, yr, mo, dt, dw, hr, mi, se);
    wr(4'h8, 8'h80);
    wr(4'h1, ce); wr(4'hF, yr); wr(4'hE, mo); wr(4'hD, dt);
    wr(4'hC, dw); wr(4'hB, hr); wr(4'hA, mi); wr(4'h9, se);
    wr(4'h8, 8'h00);
  endtask

  task automatic t_reset();
    rd_chk("R2", "ctrl after reset", 4'h8, 8'h00);
    rd_chk("R2", "seconds after reset", 4'h9, 8'h00);
    rd_chk("R2", "date after reset", 4'hD, 8'h00);
    tick();
    rd_chk("R2", "first seconds", 4'h9, 8'h01);
    rd_chk("R2", "first day", 4'hC, 8'h01);
    rd_chk("R2", "first date", 4'hD, 8'h01);
    rd_chk("R3", "first month", 4'hE, 8'h01);
  endtask

  task automatic t_storage();
    rd_chk("R1", "offset 0 idle", 4'h0, 8'h00);
    wr(4'h3, 8'hA5);
    wr(4'h7, 8'h3C);
    rd_chk("R1", "offset 3", 4'h3, 8'hA5);
    rd_chk("R1", "offset 7", 4'h7, 8'h3C);
    tick();
    rd_chk("R1", "offset 3 after refresh", 4'h3, 8'hA5);
  endtask

  task automatic t_carry();
    set_time(8'h20, 8'h23, 8'h05, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59);
    tick();
    rd_chk("R4", "sec wrap", 4'h9, 8'h00);
    rd_chk("R4", "min wrap", 4'hA, 8'h00);
    rd_chk("R4", "hour wrap", 4'hB, 8'h00);
    rd_chk("R4", "day 7 to 1", 4'hC, 8'h01);
    rd_chk("R4", "date step", 4'hD, 8'h11);
  endtask

  task automatic t_mask();
    set_time(8'h20, 8'h23, 8'hE7, 8'hC9, 8'hB3, 8'hE1, 8'h85, 8'h30);
    tick();
    rd_chk("R10", "masked seconds", 4'h9, 8'h31);
    rd_chk("R10", "masked minutes", 4'hA, 8'h05);
    rd_chk("R10", "masked hours", 4'hB, 8'h21);
    rd_chk("R10", "masked day", 4'hC, 8'h03);
    rd_chk("R10", "masked date", 4'hD, 8'h09);
    rd_chk("R10", "masked month", 4'hE, 8'h07);
  endtask

  task automatic roll_day(input logic [7:0] yr, mo, dt, exp_mo, exp_dt);
    set_time(8'h19, yr, mo, dt, 8'h05, 8'h23, 8'h59, 8'h59);
    tick();
    rd_chk("R5", "month after midnight", 4'hE, exp_mo);
    rd_chk("R5", "date after midnight", 4'hD, exp_dt);
  endtask

  task automatic t_months();
    roll_day(8'h23, 8'h04, 8'h30, 8'h05, 8'h01);
    roll_day(8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    roll_day(8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    roll_day(8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    roll_day(8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    roll_day(8'h23, 8'h01, 8'h30, 8'h01, 8'h31);
    roll_day(8'h99, 8'h12, 8'h31, 8'h01, 8'h01);
    rd_chk("R5", "year wrap", 4'hF, 8'h00);
    rd_chk("R5", "century step", 4'h1, 8'h20);
  endtask

  task automatic t_read_freeze();
    set_time(8'h20, 8'h23, 8'h06, 8'h15, 8'h02, 8'h10, 8'h20, 8'h10);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    wr(4'h8, 8'h40);
    rd_chk("R7", "refresh survives READ", 4'h9, 8'h11);
    tick();
    tick();
    rd_chk("R6", "frozen seconds", 4'h9, 8'h11);
    rd_chk("R6", "ctrl READ set", 4'h8, 8'h40);
    wr(4'h8, 8'h00);
    rd_chk("R6", "no refresh before tick", 4'h9, 8'h11);
    tick();
    rd_chk("R6", "refresh after release", 4'h9, 8'h14);
  endtask

  task automatic t_write_freeze();
    set_time(8'h20, 8'h23, 8'h06, 8'h15, 8'h02, 8'h08, 8'h00, 8'h30);
    wr(4'h8, 8'h80);
    wr(4'hB, 8'h15);
    rd_chk("R8", "loaded hour visible", 4'hB, 8'h15);
    tick();
    rd_chk("R8", "no refresh in WRITE", 4'h9, 8'h30);
    rd_chk("R8", "ctrl WRITE set", 4'h8, 8'h80);
    wr(4'h8, 8'h00);
    tick();
    rd_chk("R8", "committed seconds plus one", 4'h9, 8'h31);
    rd_chk("R8", "committed hour", 4'hB, 8'h15);
  endtask

  task automatic t_stop();
    set_time(8'h20, 8'h23, 8'h06, 8'h15, 8'h02, 8'h08, 8'h00, 8'h20);
    wr(4'h9, 8'h80);
    tick();
    tick();
    rd_chk("R9", "stopped seconds", 4'h9, 8'hA0);
    rd_chk("R9", "ctrl untouched", 4'h8, 8'h00);
    wr(4'h9, 8'h00);
    tick();
    rd_chk("R9", "resumed seconds", 4'h9, 8'h21);
    wr(4'hC, 8'h43);
    rd_chk("R9", "ftest set", 4'hC, 8'h43);
    wr(4'hC, 8'h03);
    rd_chk("R9", "ftest clear", 4'hC, 8'h03);
  endtask

  initial begin
    rst = 1'b1; sec_tick = 1'b0; wr_en = 1'b0; addr = 4'h0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_storage();
    t_carry();
    t_mask();
    t_months();
    t_read_freeze();
    t_write_freeze();
    t_stop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule